// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block produces every digital drive waveform needed to read out a colour linear image sensor that has six photosite rows behind three video outputs. It runs from one fast system clock and builds each sensor clock by counting that clock. Every edge offset and pulse width is a parameter, given in system-clock cycles. At 40 MHz one cycle is 25 ns, and the defaults give a 2 MHz shift and reset rate. The sensor clocks it drives are:

- three colour transfer gates;
- two pairs of complementary transfer clocks;
- one complementary shift pair;
- the per-pixel reset pulse.

Every line begins with a transfer window. The transfer clock is held high, the enabled colour gates pulse inside that hold, and a lag interval follows before clocking resumes. Readout comes next, in one of two modes. In dual-row mode the two rows of each colour are interleaved, so the transfer clock runs at half the shift rate. In single-row mode the transfer clock runs at the shift rate. The mode and the colour gate mask are each captured once per line. A one-cycle strobe marks the first readout cycle.

Top module: `lccd_timing_gen`

## Requirements
- R1: While `rst` is high (synchronous, active high), `xfer_a`, `xfer_la` and `shift_a` are 1, `xfer_b`, `xfer_lb` and `shift_b` are 0, and `pix_reset`, all three gates and `line_start` are 0.
- R2: A line is GATE_LEAD cycles of hold, then GATE_LEN cycles with the enabled gates high, then GATE_LAG cycles of hold, then the readout. The next line follows at once.
- R3: Throughout the transfer window (lead, gate and lag), `xfer_a`, `xfer_la` and `shift_a` stay high, and `pix_reset` stays low.
- R4: During readout, `shift_a` is high for the first SHIFT_HALF cycles of each shift period of 2·SHIFT_HALF cycles and low for the rest. `shift_b` is always its complement.
- R5: During readout, `pix_reset` is high for RS_WIDTH cycles, starting RS_START cycles after each rise of `shift_a`. It is low at all other times.
- R6: In dual-row mode (`single_line`=0 captured), readout lasts DUAL_SHIFTS shift periods. `xfer_a` is high in even-numbered periods (counting from 0) and low in odd ones. `xfer_la` equals `xfer_a`, and `xfer_b` and `xfer_lb` are its complement.
- R7: In single-row mode (`single_line`=1 captured), readout lasts SINGLE_SHIFTS shift periods and `xfer_a` equals `shift_a`.
- R8: `line_start` is high for exactly one cycle, the first readout cycle of each line.
- R9: `single_line` is captured only on the last lag cycle of each line. A change at any other time has no effect until the next line.
- R10: The gate mask `gate_mask` (bit 0 red, bit 1 green, bit 2 blue) is captured on the last lead cycle. Each gate pulses only if its bit was 1, and a mask change during the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| single_line | input | 1 | 1 selects single-row readout, 0 dual-row |
| gate_mask | input | 3 | Gate enables: bit 0 red, 1 green, 2 blue |
| gate_r | output | 1 | Red transfer gate |
| gate_g | output | 1 | Green transfer gate |
| gate_b | output | 1 | Blue transfer gate |
| xfer_a | output | 1 | Main transfer clock, phase A |
| xfer_b | output | 1 | Main transfer clock, phase B |
| xfer_la | output | 1 | Last-stage transfer clock, phase A |
| xfer_lb | output | 1 | Last-stage transfer clock, phase B |
| shift_a | output | 1 | Shift clock, phase A |
| shift_b | output | 1 | Shift clock, phase B |
| pix_reset | output | 1 | Output-node reset pulse |
| line_start | output | 1 | One-cycle strobe at the first readout cycle |

## Verification
The capture of the readout mode shares one cycle with the line-start strobe and the first shift period. The bench therefore changes `single_line` in the last lag cycle, where the new value must take effect, and in the cycle straight after it, where the change must be ignored. Both cases are judged by the length of the readout and by the phase of `xfer_a` against `shift_a`. The gate mask is treated the same way. It is changed in the middle of a gate pulse and between lines. The bench compares every output, on every clock, against a behavioural model that tracks the position in the line.

// File: rtl/lccd_timing_gen.sv
module lccd_timing_gen #(
  parameter int SHIFT_HALF    = 10,
  parameter int RS_START      = 5,
  parameter int RS_WIDTH      = 4,
  parameter int GATE_LEAD     = 4,
  parameter int GATE_LEN      = 4000,
  parameter int GATE_LAG      = 60,
  parameter int DUAL_SHIFTS   = 21610,
  parameter int SINGLE_SHIFTS = 10816
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       single_line,
  input  logic [2:0] gate_mask,
  output logic       gate_r,
  output logic       gate_g,
  output logic       gate_b,
  output logic       xfer_a,
  output logic       xfer_b,
  output logic       xfer_la,
  output logic       xfer_lb,
  output logic       shift_a,
  output logic       shift_b,
  output logic       pix_reset,
  output logic       line_start
);

  localparam int PER   = 2 * SHIFT_HALF;
  localparam int TMAX0 = (GATE_LEAD > GATE_LAG) ? GATE_LEAD : GATE_LAG;
  localparam int TMAX  = (GATE_LEN > TMAX0) ? GATE_LEN : TMAX0;
  localparam int SMAX  = (DUAL_SHIFTS > SINGLE_SHIFTS) ? DUAL_SHIFTS : SINGLE_SHIFTS;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(PER + 1);
  localparam int SW    = $clog2(SMAX + 1);

  localparam logic [TW-1:0] LEAD_LAST = TW'(GATE_LEAD - 1);
  localparam logic [TW-1:0] GATE_LAST = TW'(GATE_LEN - 1);
  localparam logic [TW-1:0] LAG_LAST  = TW'(GATE_LAG - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(PER - 1);
  localparam logic [PW-1:0] PH_HALF   = PW'(SHIFT_HALF);
  localparam logic [PW-1:0] RS_LO     = PW'(RS_START);
  localparam logic [PW-1:0] RS_HI     = PW'(RS_START + RS_WIDTH);
  localparam logic [SW-1:0] DUAL_LAST = SW'(DUAL_SHIFTS - 1);
  localparam logic [SW-1:0] SGL_LAST  = SW'(SINGLE_SHIFTS - 1);

  typedef enum logic [1:0] {S_LEAD, S_GATE, S_LAG, S_READ} state_t;

  state_t        st;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] ph;
  logic [SW-1:0] pix;
  logic          mode_q;
  logic [2:0]    mask_q;

  wire rd      = (st == S_READ);
  wire gate_win = (st == S_GATE);
  wire ph_hi   = (ph < PH_HALF);
  wire [SW-1:0] pix_last = mode_q ? SGL_LAST : DUAL_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_LEAD;
      tcnt   <= '0;
      ph     <= '0;
      pix    <= '0;
      mode_q <= 1'b0;
      mask_q <= 3'b000;
    end else begin
      case (st)
        S_LEAD:
          if (tcnt == LEAD_LAST) begin
            st     <= S_GATE;
            tcnt   <= '0;
            mask_q <= gate_mask;
          end else tcnt <= tcnt + 1'b1;
        S_GATE:
          if (tcnt == GATE_LAST) begin
            st   <= S_LAG;
            tcnt <= '0;
          end else tcnt <= tcnt + 1'b1;
        S_LAG:
          if (tcnt == LAG_LAST) begin
            st     <= S_READ;
            tcnt   <= '0;
            ph     <= '0;
            pix    <= '0;
            mode_q <= single_line;
          end else tcnt <= tcnt + 1'b1;
        default:
          if (ph == PH_LAST) begin
            ph <= '0;
            if (pix == pix_last) begin
              st  <= S_LEAD;
              pix <= '0;
            end else pix <= pix + 1'b1;
          end else ph <= ph + 1'b1;
      endcase
    end
  end

  assign shift_a    = rd ? ph_hi : 1'b1;
  assign shift_b    = ~shift_a;
  assign xfer_a     = rd ? (mode_q ? ph_hi : ~pix[0]) : 1'b1;
  assign xfer_b     = ~xfer_a;
  assign xfer_la    = xfer_a;
  assign xfer_lb    = ~xfer_a;
  assign pix_reset  = rd && (ph >= RS_LO) && (ph < RS_HI);
  assign line_start = rd && (ph == '0) && (pix == '0);
  assign gate_r     = gate_win & mask_q[0];
  assign gate_g     = gate_win & mask_q[1];
  assign gate_b     = gate_win & mask_q[2];

  // R3
  gate_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_r || gate_g || gate_b) |-> (xfer_a && shift_a && !pix_reset));

  // R3
  lag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_win) |-> (xfer_a && !line_start && !pix_reset));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |-> $stable(mode_q));

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_win && $past(gate_win)) |-> $stable({gate_b, gate_g, gate_r}));

  // R6
  dual_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && $past(rd) && !mode_q && !$stable(xfer_a)) |-> $rose(shift_a));

endmodule

// File: tb/lccd_timing_gen_test.sv
module lccd_timing_gen_test;
  localparam int H    = 4;
  localparam int RSS  = 1;
  localparam int RSW  = 2;
  localparam int LEAD = 3;
  localparam int GL   = 10;
  localparam int LAG  = 5;
  localparam int NDU  = 12;
  localparam int NSG  = 8;
  localparam int P    = 2 * H;
  localparam int W    = LEAD + GL + LAG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic single_line = 1'b0;
  logic [2:0] gate_mask = 3'b111;
  logic gate_r, gate_g, gate_b, xfer_a, xfer_b, xfer_la, xfer_lb;
  logic shift_a, shift_b, pix_reset, line_start;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int pos = 0;
  logic lmode = 1'b0;
  logic [2:0] lmask = 3'b000;

  always #10 clk = ~clk;

  lccd_timing_gen #(
    .SHIFT_HALF(H), .RS_START(RSS), .RS_WIDTH(RSW), .GATE_LEAD(LEAD),
    .GATE_LEN(GL), .GATE_LAG(LAG), .DUAL_SHIFTS(NDU), .SINGLE_SHIFTS(NSG)
  ) uut (
    .clk(clk), .rst(rst), .single_line(single_line), .gate_mask(gate_mask),
    .gate_r(gate_r), .gate_g(gate_g), .gate_b(gate_b),
    .xfer_a(xfer_a), .xfer_b(xfer_b), .xfer_la(xfer_la), .xfer_lb(xfer_lb),
    .shift_a(shift_a), .shift_b(shift_b), .pix_reset(pix_reset),
    .line_start(line_start)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", req, pos, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural line model: position within the line plus captured mode and mask
  always @(posedge clk) begin
    if (rst) begin
      pos <= 0; lmode <= 1'b0; lmask <= 3'b000;
    end else begin
      int nsh;
      logic m;
      m = (pos == W - 1) ? single_line : lmode;
      if (pos == LEAD - 1) lmask <= gate_mask;
      lmode <= m;
      nsh = m ? NSG : NDU;
      if (pos + 1 >= W + nsh * P) pos <= 0;
      else pos <= pos + 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=<20000", cyc);
      report();
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      // R1 reset state
      chk("R1", {xfer_a, xfer_b, xfer_la, xfer_lb, shift_a, shift_b, pix_reset, line_start},
          8'b1010_1000);
      chk("R1", {5'b0, gate_b, gate_g, gate_r}, 8'h00);
    end else begin
      logic e1, e3, ers, els;
      logic [2:0] eg;
      string lx, lg;
      eg = 3'b000;
      if (pos < W) begin
        e1 = 1'b1; e3 = 1'b1; ers = 1'b0; els = 1'b0;
        if (pos >= LEAD && pos < LEAD + GL) eg = lmask;
        lx = "R3";
      end else begin
        int r, ph, k;
        r = pos - W; ph = r % P; k = r / P;
        e3  = (ph < H);
        ers = (ph >= RSS) && (ph < RSS + RSW);
        e1  = lmode ? e3 : ((k % 2) == 0);
        els = (r == 0);
        lx  = (single_line != lmode) ? "R9" : (lmode ? "R7" : "R6");
      end
      lg = (pos >= LEAD && gate_mask != lmask) ? "R10" : "R2";
      chk("R4", {6'b0, shift_a, shift_b}, {6'b0, e3, ~e3});
      chk(lx, {4'b0, xfer_a, xfer_b, xfer_la, xfer_lb}, {4'b0, e1, ~e1, e1, ~e1});
      chk("R5", {7'b0, pix_reset}, {7'b0, ers});
      chk(lg, {5'b0, gate_b, gate_g, gate_r}, {5'b0, eg});
      chk("R8", {7'b0, line_start}, {7'b0, els});
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (pos != p);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // line 1: dual rows, all gates; R9 mid-line change ignored
    wait_pos(W + 20);
    single_line = 1'b1;
    // line 2 captures single-row mode at its last lag cycle
    wait_pos(W - 1);
    wait_pos(W + 10);
    gate_mask = 3'b101;
    // line 3: mask 101 captured; R10 change during the pulse is ignored
    wait_pos(LEAD + 2);
    gate_mask = 3'b010;
    single_line = 1'b0;
    // R9 boundary: set in last lag cycle (taken), clear one cycle later (ignored)
    wait_pos(W - 1);
    single_line = 1'b1;
    wait_pos(W);
    single_line = 1'b0;
    // line 4: dual rows, green only
    wait_pos(0);
    wait_pos(W + 30);
    gate_mask = 3'b000;
    // line 5: no gates
    wait_pos(0);
    wait_pos(W + 5);
    report();
  end
endmodule